// File: doc/BRIEF.md
# Serial Timeslot Channel Mapper

The mapper receives one TDM serial line, made of a bit clock, a data bit and a frame sync, and labels every received bit with the logical channel it belongs to. A bit can also be marked as belonging to no channel. A frame is 32 timeslots of 8 bits each. A table holds one entry per timeslot. Each entry carries an enable flag, a 5-bit channel id and an 8-bit mask with one bit for each bit position in the slot. Because the mask works at bit level, a single table covers three cases:

- a plain 64 kbit/s slot, which uses all 8 mask bits;
- a 56 kbit/s slot, which uses 7 mask bits;
- a hyperchannel, where several slots carry the same id, or a subchannel, where only a few bits of a slot are set.

The serial clock is asynchronous and may run at any rate up to roughly a quarter of the system clock, including arbitrarily long stalls. The line signals are synchronised and the bit clock is edge detected in the system clock domain. For each received bit the block emits one strobe together with a valid flag, the channel id and the data bit. Host writes go to a shadow copy of the table. The whole shadow copy moves into the active copy when a new frame starts, so no frame is ever mapped through a partly written table.

Top module: `tdm_slot_mapper`

## Requirements
- R1: Every rising edge of `ser_clk_i` yields exactly one `out_stb_o` pulse. That pulse carries the `ser_dat_i` value present at the edge on `out_dat_o`, and bits leave in the order they arrived.
- R2: A rising edge of `ser_fs_i`, sampled with a bit, makes that bit slot 0 bit 0. Later bits advance the bit index 0..7 within a slot and then the slot index 0..31. After slot 31 bit 7 the count wraps to slot 0 bit 0.
- R3: Bit n of slot s is valid when the entry for s is enabled and its mask bit 7-n is set, so mask bit 7 is the first bit of the slot. A valid bit reports the entry's channel id on `out_ch_o`.
- R4: Several slots, contiguous or not, that carry the same channel id all report that id, which forms an Nx64 hyperchannel.
- R5: A partial mask validates only the selected bits of a slot. This covers 56 kbit/s (mask 0xFE) and Nx8 subchannels, and different bits of one slot may belong to one id or to different ids.
- R6: A bit in a disabled slot or at an unmasked position gives `out_vld_o`=0 and `out_ch_o`=0, while its strobe and data still appear.
- R7: A map write has no effect on the rest of the current frame. It applies from slot 0 bit 0 of the next frame, whether that frame starts by wrap-around or by frame sync.
- R8: A frame sync edge that arrives when the count was not about to wrap moves the count to slot 0 bit 0 and sets `sync_err_o`. The flag stays set until reset. A frame sync at the expected position leaves the flag clear.
- R9: Until the first frame sync edge after reset, no bit is reported valid.
- R10: During and after reset, with no serial activity, `out_stb_o`, `out_vld_o` and `sync_err_o` are 0.
- R11: Results do not depend on the bit period. High and low phases of at least 4 system clocks, irregular from bit to bit, and arbitrarily long stalls are all handled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ser_clk_i | input | 1 | Serial bit clock, asynchronous; data is taken on its rising edge |
| ser_dat_i | input | 1 | Serial data bit |
| ser_fs_i | input | 1 | Frame sync; its rising edge marks slot 0 bit 0 |
| map_we_i | input | 1 | Write strobe for one table entry |
| map_slot_i | input | 5 | Timeslot whose entry is written |
| map_en_i | input | 1 | Enable flag written to the entry |
| map_ch_i | input | 5 | Channel id written to the entry |
| map_mask_i | input | 8 | Bit mask written to the entry, bit 7 = first bit of the slot |
| out_stb_o | output | 1 | One-cycle pulse per received bit |
| out_vld_o | output | 1 | Bit belongs to a channel (only with out_stb_o) |
| out_ch_o | output | 5 | Channel id of the bit, 0 when not valid |
| out_dat_o | output | 1 | Received data bit |
| sync_err_o | output | 1 | Sticky flag for a misplaced frame sync |

## Verification
The bench first sends bits before any frame sync while a fully enabled map is already loaded. This separates a mapper that waits for frame lock from one that trusts its reset count. It then loads a directed map: a full slot, a hyperchannel spread over non-adjacent slots, a 56 kbit/s slot, and two subchannels that share one id, which together tell the bit order and the mask polarity apart from a slot-level lookup. Random maps with writes at random bit positions follow, which shows whether an update stays out of the rest of its frame and starts exactly at the next frame. The run ends with a frame sync in mid-slot, which checks the resync point and the sticky error, and serial clock phases of random length, one of them a long stall, are used throughout.

// File: rtl/tdm_map_pkg.sv
package tdm_map_pkg;
  localparam int SLOTS    = 32;
  localparam int BITS     = 8;
  localparam int CHANNELS = 32;
  localparam int CH_W     = $clog2(CHANNELS);
  localparam int SLOT_W   = $clog2(SLOTS);
  localparam int BIT_W    = $clog2(BITS);

  typedef struct packed {
    logic            en;
    logic [CH_W-1:0] ch;
    logic [BITS-1:0] mask;
  } map_entry_t;
endpackage

// File: rtl/tdm_bit_sampler.sv
module tdm_bit_sampler #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ser_clk_i,
  input  logic ser_dat_i,
  input  logic ser_fs_i,
  output logic samp_o,
  output logic dat_o,
  output logic fs_o
);
  localparam int MSB = STAGES - 1;

  logic [STAGES-1:0] clk_sync_q, dat_sync_q, fs_sync_q;
  logic              clk_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_sync_q <= '0;
      dat_sync_q <= '0;
      fs_sync_q  <= '0;
      clk_prev_q <= 1'b0;
      samp_o     <= 1'b0;
      dat_o      <= 1'b0;
      fs_o       <= 1'b0;
    end else begin
      clk_sync_q <= {clk_sync_q[STAGES-2:0], ser_clk_i};
      dat_sync_q <= {dat_sync_q[STAGES-2:0], ser_dat_i};
      fs_sync_q  <= {fs_sync_q[STAGES-2:0], ser_fs_i};
      clk_prev_q <= clk_sync_q[MSB];
      // data path has same depth as clock path, so it is aligned with the edge
      samp_o     <= clk_sync_q[MSB] & ~clk_prev_q;
      dat_o      <= dat_sync_q[MSB];
      fs_o       <= fs_sync_q[MSB];
    end
  end

  p_samp_single_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    samp_o |=> !samp_o);

endmodule

// File: rtl/tdm_frame_tracker.sv
module tdm_frame_tracker
  import tdm_map_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              samp_i,
  input  logic              dat_i,
  input  logic              fs_i,
  output logic              stb_o,
  output logic              dat_o,
  output logic              locked_o,
  output logic              frame_start_o,
  output logic              err_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic [BIT_W-1:0]  bit_o
);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOTS - 1);
  localparam logic [BIT_W-1:0]  BIT_LAST  = BIT_W'(BITS - 1);

  logic              fs_last_q;
  logic              fs_rise, at_wrap;
  logic [SLOT_W-1:0] slot_nx;
  logic [BIT_W-1:0]  bit_nx;

  always_comb begin
    at_wrap = (slot_o == SLOT_LAST) && (bit_o == BIT_LAST);
    fs_rise = samp_i & fs_i & ~fs_last_q;
    slot_nx = slot_o;
    bit_nx  = bit_o + BIT_W'(1);
    if (fs_rise || at_wrap) begin
      slot_nx = '0;
      bit_nx  = '0;
    end else if (bit_o == BIT_LAST) begin
      slot_nx = slot_o + SLOT_W'(1);
      bit_nx  = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_o        <= SLOT_LAST;   // first bit after reset lands on slot 0 bit 0
      bit_o         <= BIT_LAST;
      fs_last_q     <= 1'b0;
      stb_o         <= 1'b0;
      dat_o         <= 1'b0;
      locked_o      <= 1'b0;
      frame_start_o <= 1'b0;
      err_o         <= 1'b0;
    end else begin
      stb_o         <= samp_i;
      frame_start_o <= samp_i & (fs_rise | at_wrap);
      if (samp_i) begin
        slot_o    <= slot_nx;
        bit_o     <= bit_nx;
        dat_o     <= dat_i;
        fs_last_q <= fs_i;
      end
      if (fs_rise) locked_o <= 1'b1;
      if (fs_rise && locked_o && !at_wrap) err_o <= 1'b1;
    end
  end

  p_resync_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (samp_i && fs_i && !fs_last_q) |=> (slot_o == '0 && bit_o == '0));
  p_err_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
  p_lock_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_o |=> locked_o);
  p_count_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !samp_i |=> ($stable(slot_o) && $stable(bit_o)));

endmodule

// File: rtl/tdm_map_table.sv
module tdm_map_table
  import tdm_map_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [SLOT_W-1:0] wr_slot_i,
  input  map_entry_t        wr_entry_i,
  input  logic              commit_i,
  input  logic [SLOT_W-1:0] rd_slot_i,
  output map_entry_t        rd_entry_o
);
  map_entry_t shadow_q [SLOTS];
  map_entry_t active_q [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        shadow_q[g] <= '0;
        active_q[g] <= '0;
      end else begin
        if (wr_en_i && wr_slot_i == SLOT_W'(g)) shadow_q[g] <= wr_entry_i;
        // commit copies the pre-write shadow; a same-cycle write waits a frame
        if (commit_i) active_q[g] <= shadow_q[g];
      end
    end
  end

  // first bit of a frame reads the shadow directly, it becomes active this edge
  assign rd_entry_o = commit_i ? shadow_q[rd_slot_i] : active_q[rd_slot_i];

  p_active_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> $stable(active_q[0]));

endmodule

// File: rtl/tdm_slot_mapper.sv
module tdm_slot_mapper
  import tdm_map_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ser_clk_i,
  input  logic              ser_dat_i,
  input  logic              ser_fs_i,
  input  logic              map_we_i,
  input  logic [SLOT_W-1:0] map_slot_i,
  input  logic              map_en_i,
  input  logic [CH_W-1:0]   map_ch_i,
  input  logic [BITS-1:0]   map_mask_i,
  output logic              out_stb_o,
  output logic              out_vld_o,
  output logic [CH_W-1:0]   out_ch_o,
  output logic              out_dat_o,
  output logic              sync_err_o
);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(BITS - 1);

  logic              samp_w, sdat_w, sfs_w;
  logic              stb_w, dat_w, locked_w, frame_start_w;
  logic [SLOT_W-1:0] slot_w;
  logic [BIT_W-1:0]  bit_w;
  logic [BIT_W-1:0]  mask_sel;
  map_entry_t        wr_entry, rd_entry;
  logic              hit;

  tdm_bit_sampler #(.STAGES(SYNC_STAGES)) u_sampler (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ser_clk_i (ser_clk_i),
    .ser_dat_i (ser_dat_i),
    .ser_fs_i  (ser_fs_i),
    .samp_o    (samp_w),
    .dat_o     (sdat_w),
    .fs_o      (sfs_w)
  );

  tdm_frame_tracker u_tracker (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .samp_i        (samp_w),
    .dat_i         (sdat_w),
    .fs_i          (sfs_w),
    .stb_o         (stb_w),
    .dat_o         (dat_w),
    .locked_o      (locked_w),
    .frame_start_o (frame_start_w),
    .err_o         (sync_err_o),
    .slot_o        (slot_w),
    .bit_o         (bit_w)
  );

  assign wr_entry = '{en: map_en_i, ch: map_ch_i, mask: map_mask_i};

  tdm_map_table u_table (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (map_we_i),
    .wr_slot_i  (map_slot_i),
    .wr_entry_i (wr_entry),
    .commit_i   (frame_start_w),
    .rd_slot_i  (slot_w),
    .rd_entry_o (rd_entry)
  );

  // MSB of the mask is the first bit on the line
  assign mask_sel = BIT_LAST - bit_w;
  assign hit      = stb_w & locked_w & rd_entry.en & rd_entry.mask[mask_sel];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_stb_o <= 1'b0;
      out_vld_o <= 1'b0;
      out_ch_o  <= '0;
      out_dat_o <= 1'b0;
    end else begin
      out_stb_o <= stb_w;
      out_vld_o <= hit;
      out_ch_o  <= hit ? rd_entry.ch : '0;
      if (stb_w) out_dat_o <= dat_w;
    end
  end

  p_vld_with_stb_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_vld_o |-> out_stb_o);
  p_idle_ch_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_vld_o |-> out_ch_o == '0);
  p_no_vld_unlocked_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_vld_o |-> locked_w);

endmodule

// File: tb/tdm_slot_mapper_tb.sv
module tdm_slot_mapper_tb;
  import tdm_map_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int FRAME_BITS = SLOTS * BITS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_dat = 1'b0, ser_fs = 1'b0;
  logic map_we = 1'b0, map_en = 1'b0;
  logic [SLOT_W-1:0] map_slot = '0;
  logic [CH_W-1:0]   map_ch = '0;
  logic [BITS-1:0]   map_mask = '0;
  logic out_stb, out_vld, out_dat, sync_err;
  logic [CH_W-1:0] out_ch;

  int checks = 0;
  int errors = 0;
  string cur_req = "R10";

  // bench model
  logic            sh_en [SLOTS];
  logic [CH_W-1:0] sh_ch [SLOTS];
  logic [BITS-1:0] sh_mask [SLOTS];
  logic            ac_en [SLOTS];
  logic [CH_W-1:0] ac_ch [SLOTS];
  logic [BITS-1:0] ac_mask [SLOTS];
  int   m_pos = FRAME_BITS - 1;
  bit   m_locked = 0, m_fs_last = 0, m_err = 0;
  logic [CH_W+1:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  tdm_slot_mapper u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .ser_clk_i(ser_clk), .ser_dat_i(ser_dat), .ser_fs_i(ser_fs),
    .map_we_i(map_we), .map_slot_i(map_slot), .map_en_i(map_en),
    .map_ch_i(map_ch), .map_mask_i(map_mask),
    .out_stb_o(out_stb), .out_vld_o(out_vld), .out_ch_o(out_ch),
    .out_dat_o(out_dat), .sync_err_o(sync_err)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // R1 R3 R4 R5 R6: compare every output strobe with the model, in order
  always @(negedge clk) begin
    if (rst_n && out_stb) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R1", "unexpected strobe", 1, 0);
      end else begin
        logic [CH_W+1:0] e;
        e = exp_q.pop_front();
        check({out_vld, out_ch, out_dat} == e, cur_req, "bit {vld,ch,dat}",
              int'({out_vld, out_ch, out_dat}), int'(e));
      end
    end
  end

  function automatic logic [CH_W+1:0] model_bit(input logic d, input logic fs);
    bit rise;
    int s, b;
    logic v;
    rise = fs && !m_fs_last;
    m_fs_last = fs;
    if (rise) begin
      if (m_locked && ((m_pos + 1) % FRAME_BITS) != 0) m_err = 1;
      m_pos = 0;
      m_locked = 1;
    end else begin
      m_pos = (m_pos + 1) % FRAME_BITS;
    end
    if (m_pos == 0) begin
      for (int i = 0; i < SLOTS; i++) begin
        ac_en[i] = sh_en[i]; ac_ch[i] = sh_ch[i]; ac_mask[i] = sh_mask[i];
      end
    end
    s = m_pos / BITS;
    b = m_pos % BITS;
    v = m_locked && ac_en[s] && ac_mask[s][BITS-1-b];
    return {v, v ? ac_ch[s] : CH_W'(0), d};
  endfunction

  task automatic drive_bit(input logic d, input logic fs, input int extra);
    int lo, hi;
    lo = 4 + int'($urandom % 6);
    hi = 4 + int'($urandom % 6);
    @(negedge clk);
    ser_dat = d;
    ser_fs  = fs;
    exp_q.push_back(model_bit(d, fs));
    repeat (lo + extra) @(negedge clk);
    ser_clk = 1'b1;
    repeat (hi) @(negedge clk);
    ser_clk = 1'b0;
  endtask

  task automatic host_write(input int slot, input logic en, input logic [CH_W-1:0] ch,
                            input logic [BITS-1:0] mask);
    @(negedge clk);
    map_we = 1'b1; map_slot = SLOT_W'(slot); map_en = en; map_ch = ch; map_mask = mask;
    @(negedge clk);
    map_we = 1'b0;
    sh_en[slot] = en; sh_ch[slot] = ch; sh_mask[slot] = mask;
  endtask

  // frame sync raised on each expected frame start
  task automatic run_bits(input int n, input int wr_odds);
    for (int i = 0; i < n; i++) begin
      logic fs;
      fs = ((m_pos + 1) % FRAME_BITS) == 0;
      drive_bit(1'($urandom), fs, 0);
      if (wr_odds > 0 && ($urandom % wr_odds) == 0)
        host_write(int'($urandom % SLOTS), 1'(($urandom % 4) != 0),
                   CH_W'($urandom), BITS'($urandom));
    end
  endtask

  task automatic drain();
    repeat (20) @(negedge clk);
    check(exp_q.size() == 0, "R1", "pending strobes", exp_q.size(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "R1", "watchdog expired", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0417));
    for (int i = 0; i < SLOTS; i++) begin
      sh_en[i] = 0; sh_ch[i] = '0; sh_mask[i] = '0;
      ac_en[i] = 0; ac_ch[i] = '0; ac_mask[i] = '0;
    end
    // R10: reset state
    repeat (3) @(negedge clk);
    check(out_stb == 1'b0 && out_vld == 1'b0, "R10", "outputs in reset", out_stb, 0);
    check(sync_err == 1'b0, "R10", "error in reset", sync_err, 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    check(out_stb == 1'b0, "R10", "strobe idle", out_stb, 0);
    check(sync_err == 1'b0, "R10", "error idle", sync_err, 0);

    // R9: fully enabled map, no frame sync yet -> nothing valid
    cur_req = "R9";
    for (int s = 0; s < SLOTS; s++) host_write(s, 1'b1, CH_W'(s), 8'hFF);
    for (int i = 0; i < 12; i++) drive_bit(1'($urandom), 1'b0, 0);
    drain();

    // R2 R3 R4 R5 R6: directed map
    cur_req = "R3/R4/R5/R6";
    for (int s = 0; s < SLOTS; s++) host_write(s, 1'b0, CH_W'(s), 8'hFF);
    host_write(0, 1'b1, 5'd3, 8'hFF);       // full 64k slot
    host_write(1, 1'b1, 5'd7, 8'hFF);       // hyperchannel, slots 1 5 17
    host_write(5, 1'b1, 5'd7, 8'hFF);
    host_write(17, 1'b1, 5'd7, 8'hFF);
    host_write(2, 1'b1, 5'd9, 8'hFE);       // 56k
    host_write(3, 1'b1, 5'd30, 8'h0C);      // subchannel
    host_write(4, 1'b1, 5'd30, 8'h30);
    host_write(6, 1'b1, 5'd12, 8'h81);
    host_write(7, 1'b0, 5'd13, 8'hFF);      // disabled with mask set
    for (int i = 0; i < 2 * FRAME_BITS; i++) begin
      logic fs;
      fs = (i == 0) || ((m_pos + 1) % FRAME_BITS) == 0;
      drive_bit(1'($urandom), fs, 0);
    end
    drain();
    // R8: syncs at the expected position leave the flag clear
    check(sync_err == 1'b0, "R8", "error after aligned syncs", sync_err, 0);

    // R7 R11: random maps, writes at random bit positions, irregular clock
    cur_req = "R7/R11";
    run_bits(3 * FRAME_BITS, 25);
    drive_bit(1'b1, 1'b0, 300);             // long stall on one bit
    run_bits(3 * FRAME_BITS, 25);
    drain();
    check(sync_err == 1'b0, "R8", "error before misplaced sync", sync_err, 0);

    // R8: frame sync at slot 10 bit 3 -> resync and sticky error
    cur_req = "R8/R2";
    while (((m_pos + 1) % FRAME_BITS) != 10 * BITS + 3) drive_bit(1'($urandom), 1'b0, 0);
    drive_bit(1'($urandom), 1'b1, 0);
    drive_bit(1'($urandom), 1'b0, 0);
    repeat (10) @(negedge clk);
    check(sync_err == 1'b1, "R8", "error after misplaced sync", sync_err, 1);
    check(m_err == 1'b1, "R8", "model error", m_err, 1);
    run_bits(2 * FRAME_BITS, 40);
    drain();
    check(sync_err == 1'b1, "R8", "error stays set", sync_err, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule